// File: doc/BRIEF.md
# Result bus request arbiter

This block shares one result bus among several execution units, four by default. A unit raises its request two cycles before its result is ready and holds it, with a tag on its own tag lane, until it sees its select line high. The request travels through three registered stages. The first samples the requests. The second resolves priority and returns a one-hot select to the winner. The third drives the bus valid flag and the winner's tag in the cycle when the winner presents its result.

Priority is fixed: the lowest unit index wins. A unit that loses keeps requesting and is served later. Because the request leads completion by two cycles, no operation can reach the bus in fewer than two cycles after its request is sampled. A unit that has just been selected can raise a fresh request at once. The arbiter ignores the stale copy of the served request that is still in its first stage, so no result is issued twice.

Top module: `rbus_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, every select line, bus valid and every bus tag bit are low.
- R2: At most one select line is high in any cycle.
- R3: A select line goes high exactly one cycle after the edge that sampled a request from that unit, when no lower-index unit is eligible in the same cycle. It never goes high without such a sampled request.
- R4: When several eligible requests are sampled at the same edge, the select goes to the unit with the lowest index. Unit 0 is the highest priority.
- R5: In the cycle after its select, a unit is not selected again from the request it still held while it waited for that select. Its select is never high in two consecutive cycles.
- R6: A unit that loses keeps its request and is selected in a later cycle. Every issued result appears on the bus exactly once, in issue order per unit.
- R7: Bus valid is high exactly one cycle after a select, which is two cycles after the granted request was sampled. Bus tag then equals the tag sampled with that request.
- R8: When no select was high in the previous cycle, bus valid is low and bus tag is all zeros.
- R9: The bus can carry a result in every cycle, so four simultaneous requests drain in four consecutive bus cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_UNITS | Per-unit bus request, held until select is seen |
| tag_i | input | NUM_UNITS*TAG_W | Per-unit result tag, lane i at bits [i*TAG_W +: TAG_W] |
| sel_o | output | NUM_UNITS | One-hot select returned to the winning unit |
| bus_valid_o | output | 1 | Result bus carries a result this cycle |
| bus_tag_o | output | TAG_W | Tag of the result on the bus, zero when idle |

## Verification
The bench targets the stale request that stays in the first stage for one cycle after its unit is selected. A design that did not mask it would select the same unit twice and put a duplicate tag on the bus. All four units are made to request together, so that a wrong priority order or a lost loser shows up as a misordered or missing tag. A unit that requests in every cycle checks the alternating select pattern. Random traffic from all units, followed by a drain, catches results that are dropped or delivered out of order, and tags that come out one stage early or late against the sampled request.

// File: rtl/rbus_pkg.sv
package rbus_pkg;
  // default geometry of the result bus arbiter
  localparam int unsigned RBUS_UNITS_DEF = 4;
  localparam int unsigned RBUS_TAG_W_DEF = 6;
  // cycles from a sampled request to the result on the bus
  localparam int unsigned RBUS_LEAD      = 2;
endpackage

// File: rtl/rbus_req_stage.sv
module rbus_req_stage #(
  parameter int unsigned NUM_UNITS = 4,
  parameter int unsigned TAG_W     = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_UNITS-1:0]       req_i,
  input  logic [NUM_UNITS*TAG_W-1:0] tag_i,
  output logic [NUM_UNITS-1:0]       req_q,
  output logic [NUM_UNITS*TAG_W-1:0] tag_q
);
  // request propagation stage: capture requests and their tags
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0;
      tag_q <= '0;
    end else begin
      req_q <= req_i;
      tag_q <= tag_i;
    end
  end
endmodule

// File: rtl/rbus_prio.sv
module rbus_prio #(
  parameter int unsigned NUM_UNITS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_UNITS-1:0] cand,
  output logic [NUM_UNITS-1:0] gnt
);
  localparam logic [NUM_UNITS-1:0] ONE = NUM_UNITS'(1);

  // blocked[i] is set when some lower-index candidate exists
  logic [NUM_UNITS-1:0] blocked;

  assign blocked[0] = 1'b0;
  genvar gi;
  generate
    for (gi = 1; gi < NUM_UNITS; gi++) begin : g_chain
      assign blocked[gi] = blocked[gi-1] | cand[gi-1];
    end
    for (gi = 0; gi < NUM_UNITS; gi++) begin : g_gnt
      assign gnt[gi] = cand[gi] & ~blocked[gi];
    end
  endgenerate

  // R4
  lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ((gnt - ONE) & cand) == '0);
endmodule

// File: rtl/rbus_sel_stage.sv
module rbus_sel_stage #(
  parameter int unsigned NUM_UNITS = 4,
  parameter int unsigned TAG_W     = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_UNITS-1:0]       req_q,
  input  logic [NUM_UNITS*TAG_W-1:0] tag_q,
  output logic [NUM_UNITS-1:0]       sel_o,
  output logic [TAG_W-1:0]           win_tag_o
);
  logic [NUM_UNITS-1:0] cand;
  logic [NUM_UNITS-1:0] gnt;
  logic [TAG_W-1:0]     tag_mux;

  // a request whose select is already out is a stale copy: drop it
  assign cand = req_q & ~sel_o;

  rbus_prio #(.NUM_UNITS(NUM_UNITS)) u_prio (
    .clk  (clk),
    .rst  (rst),
    .cand (cand),
    .gnt  (gnt)
  );

  always_comb begin
    tag_mux = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (gnt[i]) tag_mux = tag_mux | tag_q[i*TAG_W +: TAG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o     <= '0;
      win_tag_o <= '0;
    end else begin
      sel_o     <= gnt;
      win_tag_o <= tag_mux;
    end
  end

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_o));
  // R5
  no_reselect_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_o != '0) |=> ((sel_o & $past(sel_o)) == '0));
endmodule

// File: rtl/rbus_drive.sv
module rbus_drive #(
  parameter int unsigned NUM_UNITS = 4,
  parameter int unsigned TAG_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_UNITS-1:0] sel_i,
  input  logic [TAG_W-1:0]     win_tag_i,
  output logic                 bus_valid_o,
  output logic [TAG_W-1:0]     bus_tag_o
);
  // bus drive stage: result presented one cycle after the select
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid_o <= 1'b0;
      bus_tag_o   <= '0;
    end else begin
      bus_valid_o <= |sel_i;
      bus_tag_o   <= (|sel_i) ? win_tag_i : '0;
    end
  end
endmodule

// File: rtl/rbus_arbiter.sv
module rbus_arbiter #(
  parameter int unsigned NUM_UNITS = rbus_pkg::RBUS_UNITS_DEF,
  parameter int unsigned TAG_W     = rbus_pkg::RBUS_TAG_W_DEF
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_UNITS-1:0]       req_i,
  input  logic [NUM_UNITS*TAG_W-1:0] tag_i,
  output logic [NUM_UNITS-1:0]       sel_o,
  output logic                       bus_valid_o,
  output logic [TAG_W-1:0]           bus_tag_o
);
  logic [NUM_UNITS-1:0]       req_q;
  logic [NUM_UNITS*TAG_W-1:0] tag_q;
  logic [TAG_W-1:0]           win_tag;

  rbus_req_stage #(.NUM_UNITS(NUM_UNITS), .TAG_W(TAG_W)) u_req (
    .clk   (clk),
    .rst   (rst),
    .req_i (req_i),
    .tag_i (tag_i),
    .req_q (req_q),
    .tag_q (tag_q)
  );

  rbus_sel_stage #(.NUM_UNITS(NUM_UNITS), .TAG_W(TAG_W)) u_sel (
    .clk       (clk),
    .rst       (rst),
    .req_q     (req_q),
    .tag_q     (tag_q),
    .sel_o     (sel_o),
    .win_tag_o (win_tag)
  );

  rbus_drive #(.NUM_UNITS(NUM_UNITS), .TAG_W(TAG_W)) u_drv (
    .clk         (clk),
    .rst         (rst),
    .sel_i       (sel_o),
    .win_tag_i   (win_tag),
    .bus_valid_o (bus_valid_o),
    .bus_tag_o   (bus_tag_o)
  );

  // R3
  sel_has_request_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_o != '0) |-> ((sel_o & $past(req_i, 2)) == sel_o));
  // R7
  bus_follows_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_o != '0) |=> bus_valid_o);
  // R8
  bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_o == '0) |=> (!bus_valid_o && bus_tag_o == '0));
endmodule

// File: tb/rbus_arbiter_tb.sv
module rbus_arbiter_tb;
  localparam int N  = 4;
  localparam int TW = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst;
  logic [N-1:0]    req;
  logic [N*TW-1:0] tag;
  logic [N-1:0]    sel;
  logic            bvalid;
  logic [TW-1:0]   btag;

  rbus_arbiter #(.NUM_UNITS(N), .TAG_W(TW)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req),
    .tag_i       (tag),
    .sel_o       (sel),
    .bus_valid_o (bvalid),
    .bus_tag_o   (btag)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // unit models and history for the expected-value model
  logic [N-1:0]    pend;
  logic [3:0]      issued [N];
  logic [3:0]      done_c [N];
  logic [N-1:0]    req_h2;
  logic [N*TW-1:0] tag_h2;
  logic [N-1:0]    exp_sel_d1;
  logic            exp_val_d1;
  logic [TW-1:0]   exp_tag_d1;
  int              phase_valids;

  function automatic logic [N-1:0] lowest(input logic [N-1:0] v);
    logic [N-1:0] r = '0;
    for (int i = N-1; i >= 0; i--) if (v[i]) r = '0 | (N'(1) << i);
    return r;
  endfunction

  function automatic logic [TW-1:0] pick_tag(input logic [N-1:0] oh,
                                            input logic [N*TW-1:0] t);
    logic [TW-1:0] r = '0;
    for (int i = 0; i < N; i++) if (oh[i]) r = t[i*TW +: TW];
    return r;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic step(input logic [N-1:0] launch);
    logic [N-1:0]  es;
    logic [TW-1:0] et;
    int            u;
    @(negedge clk);
    es = lowest(req_h2 & ~exp_sel_d1);
    et = pick_tag(es, tag_h2);
    chk($countones(sel) <= 1, "R2", sel, 0);
    chk(sel == es, "R3 R4 R5 sel", sel, es);
    chk(bvalid == exp_val_d1, "R7 valid", bvalid, exp_val_d1);
    if (exp_val_d1) chk(btag == exp_tag_d1, "R7 tag", btag, exp_tag_d1);
    else chk(btag == '0, "R8 idle tag", btag, 0);
    if (bvalid) begin
      phase_valids++;
      u = int'(btag[5:4]);
      chk(btag[3:0] == done_c[u], "R6 order", btag[3:0], done_c[u]);
      done_c[u] = done_c[u] + 4'd1;
    end
    exp_sel_d1 = es;
    exp_val_d1 = (es != '0);
    exp_tag_d1 = et;
    req_h2 = req;
    tag_h2 = tag;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && sel[i]) pend[i] = 1'b0;
      if (!pend[i] && launch[i]) begin
        pend[i] = 1'b1;
        tag[i*TW +: TW] = {2'(i), issued[i]};
        issued[i] = issued[i] + 4'd1;
      end
    end
    req = pend;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] l;
    void'($urandom(32'h5eed_0417));
    rst = 1'b1; req = '0; tag = '0; pend = '0;
    req_h2 = '0; tag_h2 = '0; exp_sel_d1 = '0; exp_val_d1 = 1'b0; exp_tag_d1 = '0;
    for (int i = 0; i < N; i++) begin issued[i] = '0; done_c[i] = '0; end
    repeat (3) @(negedge clk);
    chk(sel == '0 && !bvalid && btag == '0, "R1 reset", {sel, bvalid, btag}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(sel == '0 && !bvalid && btag == '0, "R1 after reset", {sel, bvalid, btag}, 0);
    // single request from unit 2: select after one cycle, bus after two
    step(4'b0100);
    repeat (4) step('0);
    // all four at once: drained in index order on consecutive bus cycles
    phase_valids = 0;
    step(4'b1111);
    repeat (8) step('0);
    chk(phase_valids == 4, "R9 four results", phase_valids, 4);
    // unit 1 requests every cycle: served in alternate cycles only
    phase_valids = 0;
    repeat (10) step(4'b0010);
    repeat (4) step('0);
    chk(phase_valids == 5, "R5 alternate grants", phase_valids, 5);
    // units 0 and 3 compete continuously, then 3 must still drain
    repeat (6) step(4'b1001);
    repeat (6) step('0);
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      for (int i = 0; i < N; i++) l[i] = ($urandom_range(0, 99) < 30);
      step(l);
    end
    repeat (30) step('0);
    chk(pend == '0, "R6 all served", pend, 0);
    for (int i = 0; i < N; i++)
      chk(issued[i] == done_c[i], "R6 count", done_c[i], issued[i]);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule